// File: doc/BRIEF.md
# Memory-Mapped Serial RTC Bridge

This block sits between a byte-wide CPU bus and a three-wire serial real-time-clock chip. The CPU sees 64 byte locations selected by a 6-bit address. Each CPU read or write becomes one serial frame: a command byte, then a data byte, with padding bit times before and after. While the frame runs, `busy` freezes the CPU bus cycle. This is needed because the serial clock (`sclk_in`, about 50 kHz) is far slower than the system clock.

The frame moves one bit time on each falling edge of `sclk_in`. The block sees `sclk_in` through a two-flop synchronizer, so the low phase of `sclk_in` must last at least four system-clock cycles. The serial data pin is split into three ports: an output value, an output enable and an input value. For the seven timekeeping locations (addresses 0 to 6), binary data from the CPU is converted to BCD before it is sent. BCD data returned by the chip is converted back to binary. Every other address passes data through unchanged.

Top module: `rtc_serial_bridge`

## Requirements
- R1: The command byte, bit 7 down to bit 0, is {1, addr[5], addr[4:0], read}. Bit 6 (addr[5]) set selects the chip's RAM, and bit 0 is 1 for a read and 0 for a write.
- R2: `busy` goes high on the first clock edge that sees `sel` high, `rd` or `wr` high, and `busy` low.
- R3: A falling edge of `sclk_in` advances the frame on the third rising clock edge after it. `busy` falls on the edge that takes the 24th such advance.
- R4: `rtc_sclk` equals `sclk_in` gated by an enable that is true only in bit times 4 to 19. A frame therefore gives exactly 16 pulses, and `rtc_sclk` stays low while idle.
- R5: In bit times 4 to 11 the command byte is sent, and in bit times 12 to 19 the data byte. Both go least significant bit first, so 0xAA appears on the wire as 0,1,0,1,0,1,0,1.
- R6: A write drives `rtc_io_oe` high for all 24 bit times. A read drives it only for bit times 0 to 11, then releases the pin and shifts in 8 bits from `rtc_io_i`, LSB first. `rtc_io_oe` is low while idle.
- R7: `rtc_ce` is high exactly while `busy` is high.
- R8: A write to an address from 0 to 6 sends the BCD form of the binary input 0 to 99. For example, 23 is sent as 0x23.
- R9: A read from an address from 0 to 6 returns the binary value of the BCD byte received. For example, 0x59 is returned as 59.
- R10: Address 7 and addresses 8 to 63 pass data unchanged in both directions.
- R11: A request that arrives while `busy` is high is ignored, including one on the edge where `busy` falls. It does not restart or alter the running frame.
- R12: `dout` takes the converted read data on the edge where a read's `busy` falls. It then holds that value, and writes leave it unchanged.
- R13: After reset, `busy`, `rtc_ce`, `rtc_sclk`, `rtc_io_oe` and `dout` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_in | input | 1 | Slow serial bit clock |
| sel | input | 1 | Window select from the address decoder |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 6 | Byte location within the window |
| din | input | 8 | Write data from the CPU |
| dout | output | 8 | Read data to the CPU, held after each read |
| busy | output | 1 | Wait request that holds the CPU bus cycle |
| rtc_ce | output | 1 | Chip enable to the RTC |
| rtc_sclk | output | 1 | Gated serial clock to the RTC |
| rtc_io_o | output | 1 | Serial data value driven to the RTC |
| rtc_io_oe | output | 1 | Drive enable for the serial data pin |
| rtc_io_i | input | 1 | Serial data value read from the pin |

## Verification
Two events can meet on one clock edge: the last frame advance, which drops `busy`, and a fresh CPU request. To provoke this, the bench holds `sel` and `wr` asserted, with changed write data, through a whole write frame and releases them only after it observes `busy` low. The reference model checks `busy` on every clock and requires that it falls once and stays low. The serial monitor requires exactly 16 clock pulses carrying the first request's data and none from the later one.

// File: rtl/rtc_serial_bridge.sv
module rtc_serial_bridge #(
  parameter int AW   = 6,
  parameter int DW   = 8,
  parameter int PAD  = 4,
  parameter int NCLK = 7
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_in,
  input  logic          sel,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          busy,
  output logic          rtc_ce,
  output logic          rtc_sclk,
  output logic          rtc_io_o,
  output logic          rtc_io_oe,
  input  logic          rtc_io_i
);
  localparam int FW    = 2*PAD + 2*DW;
  localparam int IW    = $clog2(FW + 1);
  localparam int DRV   = PAD + DW;
  localparam int RX_LO = PAD + DW;
  localparam int RX_HI = PAD + 2*DW - 1;
  localparam int EN_HI = PAD + 2*DW;

  function automatic logic [DW-1:0] to_bcd(input logic [DW-1:0] v);
    logic [DW-1:0] t, u;
    t = v / DW'(10);
    u = v % DW'(10);
    return {t[3:0], u[3:0]};
  endfunction

  function automatic logic [DW-1:0] to_bin(input logic [DW-1:0] b);
    return {{(DW-4){1'b0}}, b[7:4]} * DW'(10) + {{(DW-4){1'b0}}, b[3:0]};
  endfunction

  logic [2:0]    sy;
  logic [IW-1:0] idx;
  logic [FW-1:0] tx, mask;
  logic [DW-1:0] rx;
  logic          rd_q, bcd_q;

  wire fall    = sy[2] & ~sy[1];
  wire start   = sel & (rd | wr) & ~busy;
  wire bcd_sel = (addr < AW'(NCLK));
  wire [DW-1:0] wdata = bcd_sel ? to_bcd(din) : din;
  wire [DW-1:0] cmd   = {1'b1, addr, rd};
  wire en = busy && (idx >= IW'(PAD)) && (idx < IW'(EN_HI));

  assign rtc_ce    = busy;
  assign rtc_sclk  = sclk_in & en;
  assign rtc_io_o  = tx[0] & busy;
  assign rtc_io_oe = mask[0] & busy;

  always_ff @(posedge clk) begin
    if (!rst_n) sy <= '0;
    else        sy <= {sy[1:0], sclk_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      tx    <= '0;
      mask  <= '0;
      rx    <= '0;
      rd_q  <= 1'b0;
      bcd_q <= 1'b0;
      dout  <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      idx   <= '0;
      tx    <= {{PAD{1'b0}}, wdata, cmd, {PAD{1'b0}}};
      mask  <= rd ? {{(FW-DRV){1'b0}}, {DRV{1'b1}}} : {FW{1'b1}};
      rd_q  <= rd;
      bcd_q <= bcd_sel;
    end else if (busy && fall) begin
      tx   <= tx >> 1;
      mask <= mask >> 1;
      idx  <= idx + 1'b1;
      if (rd_q && idx >= IW'(RX_LO) && idx <= IW'(RX_HI))
        rx <= {rtc_io_i, rx[DW-1:1]};
      if (idx == IW'(FW-1)) begin
        busy <= 1'b0;
        if (rd_q) dout <= bcd_q ? to_bin(rx) : rx;
      end
    end
  end
endmodule

// File: rtl/rtc_serial_bridge_chk.sv
module rtc_serial_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       rd,
  input logic       wr,
  input logic       busy,
  input logic       rtc_sclk,
  input logic       rtc_io_oe,
  input logic [7:0] dout
);
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && sel && (rd || wr)) |=> busy);

  p_only_on_request_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sel && (rd || wr)));

  p_sclk_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rtc_sclk);

  p_pin_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rtc_io_oe);

  p_dout_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(dout));
endmodule

bind rtc_serial_bridge rtc_serial_bridge_chk u_chk (.*);

// File: tb/rtc_serial_bridge_bench.sv
module rtc_serial_bridge_bench;
  logic clk = 0, rst_n = 0, sclk_in = 0;
  logic sel = 0, rd = 0, wr = 0, rtc_io_i = 0;
  logic [5:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic busy, rtc_ce, rtc_sclk, rtc_io_o, rtc_io_oe;

  rtc_serial_bridge u_rtc_serial_bridge (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slow serial clock: 8 cycles low, 8 high
  initial forever begin
    repeat (8) @(negedge clk);
    sclk_in = ~sclk_in;
  end

  // reference model of the frame timing
  int   hq[$];
  int   m_idx = 0;
  bit   m_busy = 0, m_pend_rd = 0;
  logic [7:0] m_dout = 0, m_pend_val = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
    if (!rst_n) begin
      hq = '{0, 0, 0};
      m_busy = 0; m_idx = 0; m_dout = 0;
    end else begin
      bit f;
      f = (hq[0] == 1) && (hq[1] == 0);
      if (m_busy && f) begin
        if (m_idx == 23) begin
          m_busy = 0;
          if (m_pend_rd) m_dout = m_pend_val;
        end
        m_idx++;
      end else if (!m_busy && sel && (rd || wr)) begin
        m_busy = 1; m_idx = 0;
      end
      hq.push_back(int'(sclk_in));
      void'(hq.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == m_busy, "R2/R3 busy", busy, m_busy);
      chk(rtc_ce == m_busy, "R7 ce", rtc_ce, m_busy);
      chk(dout == m_dout, "R12 dout", dout, m_dout);
      if (!(m_busy && m_idx >= 4 && m_idx < 20))
        chk(rtc_sclk == 0, "R4 sclk gate", rtc_sclk, 0);
      if (!m_busy) chk(rtc_io_oe == 0, "R6 idle oe", rtc_io_oe, 0);
    end
  end

  // serial monitor and RTC responder
  int pulses = 0;
  bit is_rd = 0;
  logic [7:0] resp_q = 0;
  logic [15:0] cap_io, cap_oe;

  always @(posedge rtc_sclk) begin
    if (pulses < 16) begin
      cap_io[pulses] = rtc_io_o;
      cap_oe[pulses] = rtc_io_oe;
      if (is_rd && pulses >= 8) rtc_io_i = resp_q[pulses-8];
    end
    pulses++;
  end

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic logic [7:0] bin(input logic [7:0] b);
    return 8'(int'(b[7:4]) * 10 + int'(b[3:0]));
  endfunction

  task automatic xfer(input bit r, input logic [5:0] a, input logic [7:0] v,
                      input logic [7:0] resp, input bit hold);
    logic [7:0] exp_cmd, exp_d, prev;
    exp_cmd = {1'b1, a, r};
    exp_d   = (a < 7) ? bcd(int'(v)) : v;
    prev    = dout;
    @(negedge clk);
    pulses = 0; is_rd = r; resp_q = resp;
    m_pend_rd = r;
    m_pend_val = (a < 7) ? bin(resp) : resp;
    sel = 1; rd = r; wr = !r; addr = a; din = v;
    @(negedge clk);
    chk(busy == 1, "R2 busy rise", busy, 1);
    if (hold) begin
      din = ~v;
      while (busy) @(negedge clk);
    end else begin
      sel = 0; rd = 0; wr = 0;
      while (busy) @(negedge clk);
    end
    sel = 0; rd = 0; wr = 0;
    repeat (40) @(negedge clk);
    chk(pulses == 16, "R4 pulse count", pulses, 16);
    chk(cap_io[7:0] == exp_cmd, "R1/R5 command byte", cap_io[7:0], exp_cmd);
    chk(cap_oe[7:0] == 8'hFF, "R6 command driven", cap_oe[7:0], 8'hFF);
    if (r) begin
      chk(cap_oe[15:8] == 8'h00, "R6 read released", cap_oe[15:8], 0);
      chk(dout == m_pend_val, "R9/R10/R12 read data", dout, m_pend_val);
    end else begin
      chk(cap_oe[15:8] == 8'hFF, "R6 write driven", cap_oe[15:8], 8'hFF);
      chk(cap_io[15:8] == exp_d, "R8/R10/R11 write data", cap_io[15:8], exp_d);
      chk(dout == prev, "R12 write keeps dout", dout, prev);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(busy == 0 && rtc_ce == 0, "R13 reset busy/ce", {busy, rtc_ce}, 0);
    chk(rtc_sclk == 0 && rtc_io_oe == 0, "R13 reset pins", {rtc_sclk, rtc_io_oe}, 0);
    chk(dout == 0, "R13 reset dout", dout, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    xfer(0, 6'd2, 8'd23, 8'h00, 0);        // R8 hour 23 -> 0x23
    xfer(0, 6'h20, 8'hAA, 8'h00, 0);       // R10 RAM, R5 wire order
    chk(cap_io[8] == 0 && cap_io[9] == 1 && cap_io[10] == 0 && cap_io[11] == 1,
        "R5 LSB first 0xAA", cap_io[11:8], 4'b1010);
    xfer(0, 6'd7, 8'h80, 8'h00, 0);        // R10 address 7 passes through
    xfer(1, 6'd6, 8'h00, 8'h99, 0);        // R9 0x99 -> 99
    xfer(1, 6'd0, 8'h00, 8'h59, 0);        // R9 0x59 -> 59
    xfer(1, 6'h3F, 8'h00, 8'h5A, 0);       // R10 top of window
    xfer(0, 6'd5, 8'd0, 8'h00, 0);         // R8 zero, R12 dout held
    xfer(0, 6'd4, 8'd99, 8'h00, 0);        // R8 upper bound
    xfer(1, 6'd8, 8'h00, 8'h12, 0);        // R10 first RAM-like non-clock address
    xfer(0, 6'd1, 8'd45, 8'h00, 1);        // R11 request held across frame end
    chk(busy == 0, "R11 no restart", busy, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule